// File: doc/BRIEF.md
# Stepped Potentiometer Increment-Interface Sequencer

This block sits on the host side of a stepped, non-volatile potentiometer. The potentiometer is controlled by three wires: an active-low select, a direction level and an active-low increment strobe. The block takes one command at a time over a valid/ready handshake. A command holds a direction, a step count from 0 to 127 and a store flag. The block selects the part and gives exactly that many falling edges on the increment line. It then releases select. When the store flag is set, the increment line is high at the release, which makes the part commit its wiper position. When the flag is clear, the increment line is low at the release and nothing is committed. A count of zero with the flag set only commits. A count of zero with the flag clear only selects and then deselects.

Every timing minimum is given as a parameter in nanoseconds and turned into a ceiling cycle count from `CLK_HZ`. The minimums are select-to-strobe setup, direction setup and hold, strobe low and high widths, the strobe period, the quiet time before release, and the deselect gap after a release with or without a commit.

The controller is a single state machine. Its states are `ST_IDLE`, `ST_ARM`, `ST_SETUP`, `ST_LOW`, `ST_HIGH`, `ST_HOLD` and `ST_RELEASE`. Its transitions are:
- idle → arm, on a zero-step command without commit, which lowers the strobe while the part is still deselected;
- idle → setup, on any other command;
- arm → setup;
- setup → low when steps remain, and setup → hold when none remain;
- low → high, or low → hold for the last step of a command without commit;
- high → low while steps remain, and high → hold when none remain;
- hold → release;
- release → idle.

Each state lasts its own computed cycle count, except `ST_ARM`, which lasts one cycle.

Top module: `wiper_step_sequencer`

## Requirements
- R1: After reset, and in idle, select is high (1), the increment line is high (1), `cmd_ready` is 1, `done` is 0 and `dir_up` is 0 until the first command.
- R2: A command is taken in a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` then stays low until the deselect gap has run out. `done` is high for exactly one cycle, the first cycle in which `cmd_ready` is high again.
- R3: Select is held low for max(ceil(SEL_SETUP_NS), ceil(DIR_SETUP_NS)) cycles before the first falling edge of the increment line. The increment line is high in that window unless the command has zero steps and no commit.
- R4: A command with N steps gives exactly N falling edges of the increment line while select is low. Each low phase lasts max(ceil(PULSE_MIN_NS), ceil(DIR_HOLD_NS), ceil(STEP_PERIOD_NS) − high cycles) cycles, and each high phase lasts ceil(PULSE_MIN_NS) cycles.
- R5: `dir_up` takes the command's direction (1 = toward the high end) in the cycle after acceptance. It holds that value until the next acceptance, idle included.
- R6: After the last increment activity, select stays low for ceil(RELEASE_NS) cycles before it rises.
- R7: With the store flag set, the increment line is high when select rises. Select then stays high for ceil(GAP_STORE_NS) cycles before `cmd_ready` returns.
- R8: With the store flag clear, the increment line is low when select rises. Select then stays high for ceil(GAP_NOSTORE_NS) cycles before `cmd_ready` returns. The line goes back high on the return to idle.
- R9: A zero-step command with the store flag set drives no falling edge of the increment line while select is low. Select goes through setup, the release wait and a commit release.
- R10: A zero-step command without commit lowers the increment line for one cycle while select is still high. It then selects and releases with the line still low, so no falling edge is seen while selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_dir_up | input | 1 | Direction: 1 toward high end, 0 toward low end |
| cmd_steps | input | STEP_W | Number of increment strobes |
| cmd_store | input | 1 | Commit wiper position at release |
| done | output | 1 | One-cycle pulse when the command sequence and gap have finished |
| sel_n | output | 1 | Select to the potentiometer, active low |
| inc_n | output | 1 | Increment strobe, acting on its falling edge |
| dir_up | output | 1 | Direction level to the potentiometer |

## Verification
The end of one command and the acceptance of the next can fall in the same cycle. The `done` pulse and the return of `cmd_ready` coincide, so a waiting command is taken on that very edge. The bench provokes this by raising `cmd_valid` for a second command while the first is still running, and holding it there. The reference model expects the `done` cycle and, from the next cycle on, the new select setup with the new direction. Any lost or extra idle cycle between them shows up as a mismatch in the cycle-by-cycle comparison.

// File: rtl/wss_pkg.sv
package wss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_RELEASE
    } wss_state_e;

    // ceiling of ns * hz / 1e9, never below one cycle
    function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                                 input longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c[31:0];
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wss_interval_timer.sv
module wss_interval_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/wss_step_counter.sv
module wss_step_counter #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_one,
    output logic         at_zero
);
    logic [W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     rem_q <= '0;
        else if (load)                  rem_q <= load_val;
        else if (dec && rem_q != '0)    rem_q <= rem_q - 1'b1;
    end

    assign at_one  = (rem_q == W'(1));
    assign at_zero = (rem_q == '0);
endmodule

// File: rtl/wiper_step_sequencer.sv
module wiper_step_sequencer
    import wss_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 50_000_000,
    parameter int unsigned STEP_W         = 7,
    parameter int unsigned SEL_SETUP_NS   = 100,
    parameter int unsigned DIR_SETUP_NS   = 50,
    parameter int unsigned DIR_HOLD_NS    = 100,
    parameter int unsigned PULSE_MIN_NS   = 250,
    parameter int unsigned STEP_PERIOD_NS = 1000,
    parameter int unsigned RELEASE_NS     = 1000,
    parameter int unsigned GAP_NOSTORE_NS = 100,
    parameter int unsigned GAP_STORE_NS   = 10_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_dir_up,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_store,
    output logic              done,
    output logic              sel_n,
    output logic              inc_n,
    output logic              dir_up
);
    localparam int unsigned SU_CYC  = max2(ns_to_cycles(CLK_HZ, SEL_SETUP_NS),
                                           ns_to_cycles(CLK_HZ, DIR_SETUP_NS));
    localparam int unsigned HI_CYC  = ns_to_cycles(CLK_HZ, PULSE_MIN_NS);
    localparam int unsigned PER_CYC = ns_to_cycles(CLK_HZ, STEP_PERIOD_NS);
    localparam int unsigned LO_CYC  = max2(max2(HI_CYC, ns_to_cycles(CLK_HZ, DIR_HOLD_NS)),
                                           (PER_CYC > HI_CYC) ? PER_CYC - HI_CYC : 1);
    localparam int unsigned REL_CYC = ns_to_cycles(CLK_HZ, RELEASE_NS);
    localparam int unsigned GN_CYC  = ns_to_cycles(CLK_HZ, GAP_NOSTORE_NS);
    localparam int unsigned GS_CYC  = ns_to_cycles(CLK_HZ, GAP_STORE_NS);
    localparam int unsigned MAX_CYC = max2(max2(max2(SU_CYC, LO_CYC), max2(HI_CYC, REL_CYC)),
                                           max2(GN_CYC, GS_CYC));
    localparam int unsigned TW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    wss_state_e    state_q, state_d;
    logic          store_q, zero_q;
    logic          accept, store_d, zero_d;
    logic          t_expired, rem_one, rem_zero;
    logic [TW-1:0] dur_m1;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign store_d   = accept ? cmd_store : store_q;
    assign zero_d    = accept ? (cmd_steps == '0) : zero_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = (cmd_steps == '0 && !cmd_store) ? ST_ARM : ST_SETUP;
            ST_ARM:     state_d = ST_SETUP;
            ST_SETUP:   if (t_expired) state_d = zero_q ? ST_HOLD : ST_LOW;
            ST_LOW:     if (t_expired) state_d = (rem_one && !store_q) ? ST_HOLD : ST_HIGH;
            ST_HIGH:    if (t_expired) state_d = rem_zero ? ST_HOLD : ST_LOW;
            ST_HOLD:    if (t_expired) state_d = ST_RELEASE;
            ST_RELEASE: if (t_expired) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // duration of the state being entered, minus one
    always_comb begin
        unique case (state_d)
            ST_SETUP:   dur_m1 = TW'(SU_CYC - 1);
            ST_LOW:     dur_m1 = TW'(LO_CYC - 1);
            ST_HIGH:    dur_m1 = TW'(HI_CYC - 1);
            ST_HOLD:    dur_m1 = TW'(REL_CYC - 1);
            ST_RELEASE: dur_m1 = store_d ? TW'(GS_CYC - 1) : TW'(GN_CYC - 1);
            default:    dur_m1 = '0;
        endcase
    end

    wss_interval_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_d != state_q),
        .load_val (dur_m1),
        .expired  (t_expired)
    );

    wss_step_counter #(.W(STEP_W)) u_steps (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cmd_steps),
        .dec      (state_q == ST_LOW && t_expired),
        .at_one   (rem_one),
        .at_zero  (rem_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            store_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            store_q <= store_d;
            zero_q  <= zero_d;
        end
    end

    // registered pin outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_n  <= 1'b1;
            inc_n  <= 1'b1;
            dir_up <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (accept) dir_up <= cmd_dir_up;
            done <= (state_q == ST_RELEASE) && t_expired;
            unique case (state_d)
                ST_IDLE:    begin sel_n <= 1'b1; inc_n <= 1'b1;                  end
                ST_ARM:     begin sel_n <= 1'b1; inc_n <= 1'b0;                  end
                ST_SETUP:   begin sel_n <= 1'b0; inc_n <= !(zero_d && !store_d); end
                ST_LOW:     begin sel_n <= 1'b0; inc_n <= 1'b0;                  end
                ST_HIGH:    begin sel_n <= 1'b0; inc_n <= 1'b1;                  end
                ST_HOLD:    begin sel_n <= 1'b0; inc_n <= store_d;               end
                ST_RELEASE: begin sel_n <= 1'b1; inc_n <= store_d;               end
                default:    begin sel_n <= 1'b1; inc_n <= 1'b1;                  end
            endcase
        end
    end
endmodule

// File: rtl/wss_checker.sv
module wss_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic done,
    input logic sel_n,
    input logic inc_n,
    input logic dir_up
);
    assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (sel_n && inc_n));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_done_with_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_select_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(inc_n) && !sel_n) |-> $past(!sel_n));

    assert_dir_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> $stable(dir_up));

    assert_release_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> $stable(inc_n));
endmodule

bind wiper_step_sequencer wss_checker u_wss_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .done      (done),
    .sel_n     (sel_n),
    .inc_n     (inc_n),
    .dir_up    (dir_up)
);

// File: tb/wiper_step_sequencer_bench.sv
module wiper_step_sequencer_bench;
    // 50 MHz: one cycle is 20 ns; store gap shortened to 4000 ns
    localparam int SU = 5;    // max(ceil(100/20), ceil(50/20))
    localparam int HI = 13;   // ceil(250/20)
    localparam int LO = 37;   // max(13, 5, 50-13)
    localparam int RL = 50;   // ceil(1000/20)
    localparam int GN = 5;    // ceil(100/20)
    localparam int GS = 200;  // ceil(4000/20)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_dir_up = 1'b0;
    logic [6:0] cmd_steps = '0;
    logic       cmd_store = 1'b0;
    logic       done, sel_n, inc_n, dir_up;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wiper_step_sequencer #(.CLK_HZ(50_000_000), .GAP_STORE_NS(4000)) u_wiper_step_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_dir_up(cmd_dir_up), .cmd_steps(cmd_steps), .cmd_store(cmd_store),
        .done(done), .sel_n(sel_n), .inc_n(inc_n), .dir_up(dir_up)
    );

    // expected {sel_n, inc_n, dir_up, cmd_ready, done} per cycle, with tag
    logic [4:0] exp_q[$];
    string      tag_q[$];
    logic [4:0] cur;
    string      cur_tag;
    logic       last_dir = 1'b0;
    bit         accepted;
    int         falls = 0;
    int         exp_falls = 0;
    logic       prev_inc = 1'b1;

    task automatic push(input logic s, input logic i, input logic d, input int n, input string t);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back({s, i, d, 1'b0, 1'b0});
            tag_q.push_back(t);
        end
    endtask

    task automatic build(input logic d, input int n, input logic st);
        string zt;
        zt = (n == 0) ? (st ? "R9" : "R10") : "R3";
        if (n == 0 && !st) push(1'b1, 1'b0, d, 1, "R10");
        push(1'b0, (n == 0 && !st) ? 1'b0 : 1'b1, d, SU, zt);
        for (int k = 0; k < n; k++) begin
            push(1'b0, 1'b0, d, LO, "R4");
            if (!(k == n - 1 && !st)) push(1'b0, 1'b1, d, HI, "R4");
        end
        push(1'b0, st, d, RL, (n == 0 && st) ? "R9" : "R6");
        push(1'b1, st, d, st ? GS : GN, st ? "R7" : "R8");
        exp_q.push_back({1'b1, 1'b1, d, 1'b1, 1'b1});
        tag_q.push_back("R2");
    endtask

    task automatic step_cycle();
        accepted = 1'b0;
        if (cmd_valid && cur[1]) begin
            build(cmd_dir_up, int'(cmd_steps), cmd_store);
            last_dir  = cmd_dir_up;
            exp_falls = int'(cmd_steps);
            falls     = 0;
            accepted  = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        if (exp_q.size() > 0) begin
            cur     = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
        end else begin
            cur     = {1'b1, 1'b1, last_dir, 1'b1, 1'b0};
            cur_tag = "R1";
        end
        checks++;
        if ({sel_n, inc_n, dir_up, cmd_ready, done} !== cur) begin
            errors++;
            $display("FAIL %s%s: sel_n/inc_n/dir_up/ready/done = %b expected %b",
                     cur_tag, (dir_up !== cur[2]) ? " R5" : "",
                     {sel_n, inc_n, dir_up, cmd_ready, done}, cur);
        end
        if (!sel_n && prev_inc && !inc_n) falls++;
        prev_inc = inc_n;
        if (done) begin
            checks++;
            if (falls != exp_falls) begin
                errors++;
                $display("FAIL R4/R9: falling edges while selected = %0d expected %0d", falls, exp_falls);
            end
        end
    endtask

    task automatic send(input logic d, input int n, input logic st);
        cmd_dir_up = d;
        cmd_steps  = 7'(n);
        cmd_store  = st;
        cmd_valid  = 1'b1;
        do step_cycle(); while (!accepted);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) step_cycle();
        step_cycle();
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if ({sel_n, inc_n, dir_up, cmd_ready, done} !== 5'b11010) begin
            errors++;
            $display("FAIL R1: reset outputs %b expected 11010", {sel_n, inc_n, dir_up, cmd_ready, done});
        end
        rst_n = 1'b1;
        cur = {1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
        cur_tag = "R1";
        repeat (3) step_cycle();

        send(1'b1, 3, 1'b1);              // R4 R7: steps up, commit
        drain();

        send(1'b0, 2, 1'b0);              // R8: steps down, no commit
        cmd_dir_up = 1'b1;                // R5: fields change while busy, valid low
        cmd_steps  = 7'd9;
        repeat (20) step_cycle();
        drain();

        send(1'b1, 0, 1'b1);              // R9: commit only
        drain();

        send(1'b0, 0, 1'b0);              // R10: deselect only
        drain();

        send(1'b1, 1, 1'b0);              // R4 R8: single step
        drain();

        send(1'b0, 4, 1'b1);              // R2: back-to-back, second waits on valid
        send(1'b1, 2, 1'b0);
        drain();

        send(1'b0, 127, 1'b1);            // R4: largest count
        drain();

        repeat (5) step_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule